// File: doc/BRIEF.md
# Multiport Register File with Same-Cycle Forwarding

This block is the architectural register file of an out-of-order core. It has a configurable number of write ports and read ports. The registers are built from flip-flops. When a read port addresses a register that a write port is writing in the same cycle, the read port returns the incoming write data combinationally in that cycle.

The ordinary read ports therefore double as the result-forwarding path, and function units waiting on operands see a result without an extra cycle of delay. The forwarding logic is a set of address comparators and multiplexers placed after the flip-flop array. No cell inside the array is read and written through one path.

If several write ports target one register in the same cycle, the highest-numbered port wins. This holds both for what is stored and for what is forwarded. Each read port has an enable, and a disabled read port outputs zero. Addresses at or above the register count fall outside the file.

Top module: `mprf_top`

## Requirements
- R1: A synchronous reset, active high, clears every register to zero and takes priority over any write in the same cycle. After reset, every enabled in-range read with no same-cycle write returns zero.
- R2: An enabled read of an in-range register that no enabled write port addresses in the same cycle returns the value committed at the previous rising clock edge.
- R3: An enabled read of an in-range register that an enabled write port addresses in the same cycle returns that port's write data in the same cycle, with no added clock cycle.
- R4: When several enabled write ports address the same register in one cycle, the register stores the data of the highest-numbered of those ports.
- R5: When several enabled write ports address the register being read in one cycle, the read returns the data of the highest-numbered of those ports.
- R6: A write port whose enable is low changes no register and forwards nothing, whatever its address and data.
- R7: A read port whose enable is low outputs all zeros.
- R8: An address at or above the register count addresses nothing. A write to it changes no register, and an enabled read of it returns zero, even while a write port uses the same address.
- R9: Enabled write ports that address distinct registers in the same cycle all take effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | NWR | Write enable, one bit per write port |
| wr_addr | input | NWR*AW | Write addresses; port k uses bits [k*AW +: AW] |
| wr_data | input | NWR*DW | Write data; port k uses bits [k*DW +: DW] |
| rd_en | input | NRD | Read enable, one bit per read port |
| rd_addr | input | NRD*AW | Read addresses; port k uses bits [k*AW +: AW] |
| rd_data | output | NRD*DW | Read data; port k drives bits [k*DW +: DW] |

AW is $clog2(NREG).

## Verification
The bench builds the file with 12 registers, 16-bit data, three read ports and three write ports. Because 12 is not a power of two, the 4-bit address reaches the four codes from 12 to 15, which makes the out-of-range rules reachable. Three write ports allow two-way and three-way conflicts on one register, so the priority order can be seen beyond a plain pair. Random addresses are drawn from a narrow pool, so same-cycle read/write collisions and write/write collisions occur in most cycles.

// File: rtl/mprf_pkg.sv
package mprf_pkg;

    // Where a read port takes its value from in the current cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CELL = 2'd1,
        SRC_FWD  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/mprf_write_merge.sv
// Resolves all write ports into one enable and one data word per register.
// A later (higher-numbered) port overrides an earlier one.
module mprf_write_merge #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int NWR  = 2,
    parameter int AW   = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NWR-1:0]                 wr_en,
    input  logic [NWR-1:0][AW-1:0]         wr_addr,
    input  logic [NWR-1:0][DW-1:0]         wr_data,
    output logic [NREG-1:0]                cell_we,
    output logic [NREG-1:0][DW-1:0]        cell_wd
);

    always_comb begin
        cell_we = '0;
        cell_wd = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p] && (int'(wr_addr[p]) == r)) begin
                    cell_we[r] = 1'b1;
                    cell_wd[r] = wr_data[p];
                end
            end
        end
    end

    // The top write port always reaches the register it addresses
    generate
        for (genvar r = 0; r < NREG; r++) begin : g_chk
            p_top_port_wins_r4: assert property (@(posedge clk) disable iff (rst)
                (wr_en[NWR-1] && (int'(wr_addr[NWR-1]) == r))
                |-> (cell_we[r] && (cell_wd[r] == wr_data[NWR-1])));
        end
    endgenerate

    // A register nobody addresses with an enabled port sees no write
    p_no_stray_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en == '0) |-> (cell_we == '0));

endmodule

// File: rtl/mprf_storage.sv
// Flip-flop array, two-process style.
module mprf_storage #(
    parameter int NREG = 32,
    parameter int DW   = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NREG-1:0]                cell_we,
    input  logic [NREG-1:0][DW-1:0]        cell_wd,
    output logic [NREG-1:0][DW-1:0]        cells
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (cell_we[r]) begin
                    st_d.regs[r] = cell_wd[r];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cells = st_q.regs;

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cells == '0));

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_chk
            p_commit_r2: assert property (@(posedge clk) disable iff (rst)
                ($past(cell_we[r]) && !$past(rst)) |-> (cells[r] == $past(cell_wd[r])));
            p_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (!$past(cell_we[r]) && !$past(rst)) |-> (cells[r] == $past(cells[r])));
        end
    endgenerate

endmodule

// File: rtl/mprf_read_port.sv
// One read port: stored value, overridden by any same-cycle write that
// matches the address; the highest matching write port takes precedence.
module mprf_read_port
    import mprf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int NWR  = 2,
    parameter int AW   = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_en,
    input  logic [AW-1:0]                  rd_addr,
    input  logic [NREG-1:0][DW-1:0]        cells,
    input  logic [NWR-1:0]                 wr_en,
    input  logic [NWR-1:0][AW-1:0]         wr_addr,
    input  logic [NWR-1:0][DW-1:0]         wr_data,
    output logic [DW-1:0]                  rd_data
);

    rd_src_e       src;
    logic          in_range;

    assign in_range = (int'(rd_addr) < NREG);

    always_comb begin
        rd_data = '0;
        src     = SRC_NONE;
        if (rd_en && in_range) begin
            rd_data = cells[rd_addr];
            src     = SRC_CELL;
            for (int p = 0; p < NWR; p++) begin
                if (wr_en[p] && (wr_addr[p] == rd_addr)) begin
                    rd_data = wr_data[p];
                    src     = SRC_FWD;
                end
            end
        end
    end

    p_fwd_top_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (int'(rd_addr) < NREG) && wr_en[NWR-1] && (wr_addr[NWR-1] == rd_addr))
        |-> (rd_data == wr_data[NWR-1]));

    p_fwd_src_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (int'(rd_addr) < NREG) && (wr_en != '0) && (wr_addr[0] == rd_addr) && wr_en[0])
        |-> (src == SRC_FWD));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    p_outside_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= NREG) |-> (rd_data == '0));

endmodule

// File: rtl/mprf_top.sv
module mprf_top #(
    parameter  int NREG = 32,
    parameter  int DW   = 32,
    parameter  int NRD  = 4,
    parameter  int NWR  = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NWR-1:0]        wr_en,
    input  logic [NWR*AW-1:0]     wr_addr,
    input  logic [NWR*DW-1:0]     wr_data,
    input  logic [NRD-1:0]        rd_en,
    input  logic [NRD*AW-1:0]     rd_addr,
    output logic [NRD*DW-1:0]     rd_data
);

    logic [NWR-1:0][AW-1:0]   waddr_v;
    logic [NWR-1:0][DW-1:0]   wdata_v;
    logic [NRD-1:0][AW-1:0]   raddr_v;
    logic [NRD-1:0][DW-1:0]   rdata_v;
    logic [NREG-1:0]          cell_we;
    logic [NREG-1:0][DW-1:0]  cell_wd;
    logic [NREG-1:0][DW-1:0]  cells;

    assign waddr_v = wr_addr;
    assign wdata_v = wr_data;
    assign raddr_v = rd_addr;
    assign rd_data = rdata_v;

    mprf_write_merge #(.NREG(NREG), .DW(DW), .NWR(NWR), .AW(AW)) u_merge (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (waddr_v),
        .wr_data (wdata_v),
        .cell_we (cell_we),
        .cell_wd (cell_wd)
    );

    mprf_storage #(.NREG(NREG), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cell_we (cell_we),
        .cell_wd (cell_wd),
        .cells   (cells)
    );

    generate
        for (genvar k = 0; k < NRD; k++) begin : g_rd
            mprf_read_port #(.NREG(NREG), .DW(DW), .NWR(NWR), .AW(AW)) u_rd (
                .clk     (clk),
                .rst     (rst),
                .rd_en   (rd_en[k]),
                .rd_addr (raddr_v[k]),
                .cells   (cells),
                .wr_en   (wr_en),
                .wr_addr (waddr_v),
                .wr_data (wdata_v),
                .rd_data (rdata_v[k])
            );
        end
    endgenerate

endmodule

// File: tb/mprf_top_test.sv
`timescale 1ns/1ps
module mprf_top_test;

    localparam int NREG = 12;
    localparam int DW   = 16;
    localparam int NRD  = 3;
    localparam int NWR  = 3;
    localparam int AW   = 4;
    localparam int NRAND = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NWR-1:0]          wen = '0;
    logic [NWR-1:0][AW-1:0]  wad = '0;
    logic [NWR-1:0][DW-1:0]  wdt = '0;
    logic [NRD-1:0]          ren = '0;
    logic [NRD-1:0][AW-1:0]  rad = '0;
    logic [NRD*DW-1:0]       rd_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int model [NREG];

    always #2 clk = ~clk;

    mprf_top #(.NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wen),
        .wr_addr (wad),
        .wr_data (wdt),
        .rd_en   (ren),
        .rd_addr (rad),
        .rd_data (rd_data)
    );

    function automatic int expect_rd(int k);
        int v;
        int a;
        int nhit;
        a = int'(rad[k]);
        if (!ren[k]) return 0;
        if (a >= NREG) return 0;
        v = model[a];
        nhit = 0;
        for (int p = 0; p < NWR; p++) begin
            if (wen[p] && int'(wad[p]) == a) begin
                v = int'(wdt[p]);
                nhit++;
            end
        end
        return v;
    endfunction

    function automatic string tag_rd(int k);
        int a;
        int nhit;
        a = int'(rad[k]);
        if (!ren[k]) return "R7";
        if (a >= NREG) return "R8";
        nhit = 0;
        for (int p = 0; p < NWR; p++)
            if (wen[p] && int'(wad[p]) == a) nhit++;
        if (nhit > 1) return "R5";
        if (nhit == 1) return "R3";
        return "R2";
    endfunction

    task automatic check(string req, int got, int exp_v);
        checks++;
        if (got != exp_v) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp_v);
        end
    endtask

    // Compare every read port against the model for the current inputs
    task automatic check_reads(string force_tag);
        for (int k = 0; k < NRD; k++) begin
            string t;
            t = (force_tag != "") ? force_tag : tag_rd(k);
            check(t, int'(rd_data[k*DW +: DW]), expect_rd(k));
        end
    endtask

    // Inputs are already driven (after a falling edge); check, clock, update model
    task automatic cycle(string force_tag);
        #1;
        if (!rst) check_reads(force_tag);
        @(posedge clk);
        if (rst) begin
            for (int r = 0; r < NREG; r++) model[r] = 0;
        end else begin
            for (int p = 0; p < NWR; p++)
                if (wen[p] && int'(wad[p]) < NREG) model[int'(wad[p])] = int'(wdt[p]);
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        wen = '0; wad = '0; wdt = '0; ren = '0; rad = '0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = 32'h5a5a;
        // Reset, with a write pending to prove reset priority (R1)
        rst = 1'b1;
        wen = 3'b001; wad[0] = 4'd3; wdt[0] = 16'hbeef;
        @(negedge clk);
        cycle("");
        cycle("");
        rst = 1'b0;
        idle_inputs();
        // R1: every register reads zero after reset
        for (int r = 0; r < NREG; r += NRD) begin
            ren = '1;
            for (int k = 0; k < NRD; k++) rad[k] = AW'(r + k);
            cycle("R1");
        end

        // R9: three ports write distinct registers in one cycle
        idle_inputs();
        wen = 3'b111;
        wad[0] = 4'd1; wdt[0] = 16'h1111;
        wad[1] = 4'd2; wdt[1] = 16'h2222;
        wad[2] = 4'd3; wdt[2] = 16'h3333;
        cycle("");
        idle_inputs();
        ren = '1; rad[0] = 4'd1; rad[1] = 4'd2; rad[2] = 4'd3;
        cycle("R9");

        // R4: ports 0 and 2 both write register 5; port 2 must be stored
        idle_inputs();
        wen = 3'b101;
        wad[0] = 4'd5; wdt[0] = 16'haaaa;
        wad[2] = 4'd5; wdt[2] = 16'hcccc;
        cycle("");
        idle_inputs();
        ren = 3'b001; rad[0] = 4'd5;
        cycle("R4");
        // R4 three-way conflict
        wen = 3'b111;
        wad[0] = 4'd6; wdt[0] = 16'h0101;
        wad[1] = 4'd6; wdt[1] = 16'h0202;
        wad[2] = 4'd6; wdt[2] = 16'h0303;
        ren = 3'b000;
        cycle("");
        idle_inputs();
        ren = 3'b001; rad[0] = 4'd6;
        cycle("R4");

        // R5: same-cycle read while ports 0 and 1 collide on register 7
        idle_inputs();
        wen = 3'b011;
        wad[0] = 4'd7; wdt[0] = 16'h7070;
        wad[1] = 4'd7; wdt[1] = 16'h7171;
        ren = 3'b001; rad[0] = 4'd7;
        cycle("R5");

        // R3: forward a single write to all three read ports
        idle_inputs();
        wen = 3'b010; wad[1] = 4'd9; wdt[1] = 16'h9999;
        ren = '1; rad[0] = 4'd9; rad[1] = 4'd9; rad[2] = 4'd9;
        cycle("R3");

        // R6: disabled port with live address/data neither forwards nor stores
        idle_inputs();
        wen = 3'b000; wad[2] = 4'd9; wdt[2] = 16'hdead;
        ren = 3'b001; rad[0] = 4'd9;
        cycle("R6");
        idle_inputs();
        ren = 3'b001; rad[0] = 4'd9;
        cycle("R6");

        // R8: write to 13 while reading 13; then confirm nothing aliased
        idle_inputs();
        wen = 3'b001; wad[0] = 4'd13; wdt[0] = 16'hfeed;
        ren = 3'b011; rad[0] = 4'd13; rad[1] = 4'd1;
        cycle("R8");
        idle_inputs();
        ren = '1; rad[0] = 4'd1; rad[1] = 4'd5; rad[2] = 4'd13;
        cycle("R8");

        // R7: read enable low with a matching write
        idle_inputs();
        wen = 3'b001; wad[0] = 4'd2; wdt[0] = 16'h4242;
        ren = 3'b000; rad[0] = 4'd2; rad[1] = 4'd2;
        cycle("R7");

        // Random phase with narrow address pool for frequent collisions
        for (int n = 0; n < NRAND; n++) begin
            for (int p = 0; p < NWR; p++) begin
                wen[p] = ($urandom_range(0, 3) != 0);
                wad[p] = AW'($urandom_range(0, (n % 4 == 0) ? 15 : 4));
                wdt[p] = DW'($urandom);
            end
            for (int k = 0; k < NRD; k++) begin
                ren[k] = ($urandom_range(0, 5) != 0);
                rad[k] = AW'($urandom_range(0, (n % 4 == 0) ? 15 : 4));
            end
            cycle("");
        end

        // R2: read back every register with no writes against the model
        idle_inputs();
        for (int r = 0; r < NREG; r += NRD) begin
            ren = '1;
            for (int k = 0; k < NRD; k++) rad[k] = AW'(r + k);
            cycle("R2");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule